// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces a pulse-width modulated pin from an 8-bit period value and a 10-bit duty value. The duty is given as an 8-bit high part and a 2-bit low part. An 8-bit timer, extended below by two sub-count bits, forms a 10-bit time base that advances once per count-enable pulse (`tick`). The count-enable stands in for an external clock prescaler.

Each period begins when the 8-bit timer has equalled the period value and the sub-count wraps. At that point the time base returns to zero, the output goes high, and the live duty inputs are copied into a shadow register. The output falls when the 10-bit time base reaches the shadow duty. It then stays low until the next period begins. Duty writes made during a period therefore take effect only in the following period. The shadow can be read back but has no write path.

The pin is shared with a general-purpose port latch. When the mode field does not select PWM, the pin follows the port data bit and the PWM state is held cleared. The direction bit alone decides whether the pin is driven.

Top module: `pwm10_dbuf`

## Requirements
- R1: During and after reset, the timer, the sub-count and the shadow duty are zero and the PWM output is low, so with PWM mode selected the pin reads 0 and `duty_rd` reads 0.
- R2: At each period start the shadow duty is loaded with `{duty_hi, duty_lo}`, where `duty_lo` forms bits 1:0 and `duty_hi` forms bits 9:2. The value is readable on `duty_rd`.
- R3: One period lasts (`period` + 1) × 4 count-enable pulses. The period ends on the pulse at which the timer equals `period` and the sub-count is 3.
- R4: Within a period the output is high while the time base is below the shadow duty. After that it is low until the next period start.
- R5: Changing `duty_hi` or `duty_lo` during a period does not alter the shadow or the output of that period. The new value applies from the next period start.
- R6: A shadow duty of 0 gives a constant low output. A shadow duty at or above the period span gives a constant high output.
- R7: When `mode` is not 2'b11 (PWM), `pin_o` equals `port_dat`, and the timer, sub-count, shadow and output are held at zero.
- R8: `pin_oe` equals `dir_out` (1 = drive) in every mode.
- R9: In a cycle where `tick` is low, the time base and the output do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable for the time base |
| mode | input | 2 | Mode field; 2'b11 selects PWM |
| period | input | 8 | Period compare value for the 8-bit timer |
| duty_hi | input | 8 | Duty bits 9:2 |
| duty_lo | input | 2 | Duty bits 1:0 |
| port_dat | input | 1 | Port data latch value used when PWM is off |
| dir_out | input | 1 | Pin direction, 1 = output |
| pin_o | output | 1 | Pin value |
| pin_oe | output | 1 | Pin output enable |
| duty_rd | output | 10 | Shadow duty read-back |

## Verification
The bench changes the duty a few ticks into a period. A design that loads the duty straight away, without the shadow, shortens the current pulse and fails there. Duties of 0, exactly the period span, and the 10-bit maximum are all run. A comparator that uses only the 8-bit timer, or that misplaces the two low bits, would then give the wrong pulse width or a glitch at the period start. Sparse `tick` patterns catch a time base that counts on clocks instead of pulses. Toggling the port bit with PWM off, and dropping the direction bit, shows a pin mux or enable that ignores the mode.

// File: rtl/pwm10_dbuf.sv
module pwm10_dbuf #(
  parameter int TMR_W  = 8,
  parameter int SUB_W  = 2,
  parameter int MODE_W = 2,
  parameter logic [MODE_W-1:0] MODE_PWM = 2'b11,
  localparam int DW = TMR_W + SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [MODE_W-1:0] mode,
  input  logic [TMR_W-1:0]  period,
  input  logic [TMR_W-1:0]  duty_hi,
  input  logic [SUB_W-1:0]  duty_lo,
  input  logic              port_dat,
  input  logic              dir_out,
  output logic              pin_o,
  output logic              pin_oe,
  output logic [DW-1:0]     duty_rd
);

  logic [TMR_W-1:0] tmr_q;
  logic [SUB_W-1:0] sub_q;
  logic [DW-1:0]    shd_q;
  logic             pwm_q;

  wire          active   = (mode == MODE_PWM);
  wire          per_hit  = (tmr_q == period) && (&sub_q);
  wire [DW-1:0] base_nx  = {tmr_q, sub_q} + DW'(1);
  wire [DW-1:0] duty_new = {duty_hi, duty_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      sub_q <= '0;
      shd_q <= '0;
      pwm_q <= 1'b0;
    end else if (!active) begin
      tmr_q <= '0;
      sub_q <= '0;
      shd_q <= '0;
      pwm_q <= 1'b0;
    end else if (tick) begin
      if (per_hit) begin
        tmr_q <= '0;
        sub_q <= '0;
        shd_q <= duty_new;
        pwm_q <= |duty_new;
      end else begin
        {tmr_q, sub_q} <= base_nx;
        if (base_nx == shd_q) pwm_q <= 1'b0;
      end
    end
  end

  assign pin_o   = active ? pwm_q : port_dat;
  assign pin_oe  = dir_out;
  assign duty_rd = shd_q;

  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick && per_hit) |=> (duty_rd == $past(duty_new)) && (tmr_q == '0) && (sub_q == '0));

  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !(tick && per_hit)) |=> $stable(duty_rd));

  p_low_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !pwm_q && !(tick && per_hit)) |=> !pwm_q);

  p_zero_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && shd_q == '0) |-> !pin_o);

  p_off_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (tmr_q == '0) && (sub_q == '0) && (duty_rd == '0) && !pwm_q);

  p_no_tick_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(tmr_q) && $stable(sub_q) && $stable(pwm_q));

endmodule

// File: tb/pwm10_dbuf_tb_top.sv
module pwm10_dbuf_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [1:0] mode = 2'b11;
  logic [7:0] period = 8'd4;
  logic [7:0] duty_hi = 8'd2;
  logic [1:0] duty_lo = 2'd2;
  logic port_dat = 1'b0;
  logic dir_out = 1'b1;
  logic pin_o, pin_oe;
  logic [9:0] duty_rd;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  logic [7:0] m_cnt = '0;
  logic [1:0] m_sub = '0;
  logic [9:0] m_sh = '0;

  logic [11:0] q_exp[$];
  string q_tag[$];

  always #4 clk = ~clk;

  pwm10_dbuf dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .period(period),
    .duty_hi(duty_hi), .duty_lo(duty_lo), .port_dat(port_dat), .dir_out(dir_out),
    .pin_o(pin_o), .pin_oe(pin_oe), .duty_rd(duty_rd)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic step(input bit tk, input string tag);
    logic [9:0] base;
    logic exp_pin;
    tick = tk;
    @(posedge clk); #1;
    if (mode != 2'b11) begin
      m_cnt = '0; m_sub = '0; m_sh = '0;
    end else if (tk) begin
      if (m_cnt == period && m_sub == 2'd3) begin
        m_cnt = '0; m_sub = '0; m_sh = {duty_hi, duty_lo};
      end else begin
        {m_cnt, m_sub} = {m_cnt, m_sub} + 10'd1;
      end
    end
    base = {m_cnt, m_sub};
    exp_pin = (mode == 2'b11) ? (base < m_sh) : port_dat;
    q_exp.push_back({exp_pin, dir_out, m_sh});
    q_tag.push_back(tag);
    @(negedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [11:0] e, a;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      a = {pin_o, pin_oe, duty_rd};
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s pin/oe/duty actual=%b/%b/%0d expected=%b/%b/%0d",
                 t, a[11], a[10], a[9:0], e[11], e[10], e[9:0]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000) begin
      bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (pin_o !== 1'b0 || duty_rd !== 10'd0) begin
      bad++;
      $display("FAIL R1 reset pin/duty actual=%b/%0d expected=0/0", pin_o, duty_rd);
    end
    #1 rst_n = 1'b1;
    for (int i = 0; i < 20; i++) step(1, "R1");
    for (int i = 0; i < 40; i++) step(1, "R4");
    for (int i = 0; i < 60; i++) step(i % 3 == 0, "R9");
    while (!(m_cnt == 8'd1 && m_sub == 2'd1)) step(1, "R4");
    duty_hi = 8'd0; duty_lo = 2'd3;
    for (int i = 0; i < 40; i++) step(1, "R5");
    duty_hi = 8'd1; duty_lo = 2'd3;
    for (int i = 0; i < 44; i++) step(1, "R2");
    duty_hi = 8'd0; duty_lo = 2'd0;
    for (int i = 0; i < 44; i++) step(1, "R6");
    duty_hi = 8'hFF; duty_lo = 2'd3;
    for (int i = 0; i < 44; i++) step(1, "R6");
    duty_hi = 8'd5; duty_lo = 2'd0;
    for (int i = 0; i < 44; i++) step(1, "R6");
    mode = 2'b01;
    for (int i = 0; i < 10; i++) begin
      port_dat = ~port_dat;
      step(1, "R7");
    end
    period = 8'd0;
    duty_hi = 8'd0; duty_lo = 2'd2;
    mode = 2'b11;
    for (int i = 0; i < 20; i++) step(1, "R3");
    period = 8'd9;
    for (int i = 0; i < 90; i++) step(1, "R3");
    dir_out = 1'b0;
    for (int i = 0; i < 6; i++) step(1, "R8");
    mode = 2'b00;
    port_dat = 1'b1;
    for (int i = 0; i < 6; i++) step(i % 2 == 0, "R8");
    repeat (2) @(negedge clk);
    summary();
  end
endmodule